// File: doc/BRIEF.md
# Lockstep Execution Pipe with Writeback Buffer

The block is a fixed-depth execution pipe. Each stage holds one instruction slot: a tag, a flag for a register result, and flags for one memory read and one memory write. Unless something holds them, all slots advance together by one stage per cycle. A slot that leaves the last stage either retires at once, if it produces no register result, or enters a small bounded writeback queue. That queue drains to the register-file write port at most once per cycle, and only while the external write-permission input is high.

Memory reads and writes use request/reply handshakes with fixed check points. A request is raised when the instruction sits in its issue stage. The matching reply, identified by tag, must be seen no later than the cycle in which the instruction occupies the check stage, which lies a fixed number of stages further on. If the reply is missing there, every stage from 1 upward freezes until it arrives. A reply that comes early is remembered. The pipe also freezes when its last stage holds a result-producing instruction and the writeback queue has no room.

A mode input selects the issue rule. In pipelined mode an instruction is accepted whenever stage 0 will be free. In sequential mode only one instruction may be in flight. A saturating counter reports how many cycles were lost to memory waits.

Top module: `lsp_pipe`

## Requirements
- R1: After reset no slot is occupied, `in_ready` is 1, and `wb_valid`, `retire_valid`, `ld_req_valid`, `st_req_valid` and `mem_stall_cycles` are all 0.
- R2: In pipelined mode with no stalls, an instruction accepted at clock edge k with `in_wr`=0 shows `retire_valid`=1 with its tag right after edge k+DEPTH. Instructions accepted on consecutive edges retire on consecutive cycles, in order.
- R3: With `mode_pipelined`=0, `in_ready` is 0 while any stage other than the last holds an instruction. It returns to 1 in the cycle the instruction sits in the last stage.
- R4: Instructions with `in_wr`=1 leave through `wb_valid`/`wb_tag` in acceptance order. At most one leaves per cycle, one edge after the edge at which a granted head entry is popped.
- R5: While `wr_grant` is 0, `wb_valid` stays 0 and the queued entries are kept.
- R6: If the last stage holds an instruction with `in_wr`=1 and the queue holds WBQ_DEPTH entries with no pop in that cycle, the pipe does not advance. A pop and the push from the last stage may occur in the same cycle.
- R7: A memory read request (`ld_req_valid`=1, `ld_req_tag`) is raised for exactly one cycle, in the cycle its instruction first occupies stage LD_STAGE.
- R8: A read whose reply has not been seen by the cycle its instruction sits in stage LD_STAGE+LD_LAT freezes stages 1 to DEPTH-1. Each such cycle adds one to the retire latency.
- R9: A reply whose tag matches an instruction between its issue stage and its check stage is remembered, so a reply that arrives before the check stage causes no freeze.
- R10: Memory writes follow R7 to R9 using ST_STAGE and ST_LAT and the `st_*` ports.
- R11: `mem_stall_cycles` adds one for each cycle frozen by a missing read or write reply, and saturates. Cycles frozen only by a full writeback queue do not count.
- R12: In pipelined mode `in_ready` is 1 while stage 0 is empty, even while the pipe is frozen. A frozen pipe with stage 0 occupied gives `in_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pipelined | input | 1 | 1: pipelined issue, 0: one instruction in flight |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when both valid and ready |
| in_tag | input | TAG_W | Unique tag of the offered instruction |
| in_wr | input | 1 | Instruction writes a register |
| in_ld | input | 1 | Instruction performs one memory read |
| in_st | input | 1 | Instruction performs one memory write |
| ld_req_valid | output | 1 | Memory read request |
| ld_req_tag | output | TAG_W | Tag of the read request |
| ld_rsp_valid | input | 1 | Memory read reply |
| ld_rsp_tag | input | TAG_W | Tag of the read reply |
| st_req_valid | output | 1 | Memory write request |
| st_req_tag | output | TAG_W | Tag of the write request |
| st_rsp_valid | input | 1 | Memory write reply |
| st_rsp_tag | input | TAG_W | Tag of the write reply |
| wr_grant | input | 1 | Register-file write permitted this cycle |
| wb_valid | output | 1 | Register write performed (one-cycle pulse) |
| wb_tag | output | TAG_W | Tag of the written instruction |
| retire_valid | output | 1 | Instruction without register result retired (one-cycle pulse) |
| retire_tag | output | TAG_W | Tag of the retired instruction |
| mem_stall_cycles | output | CNT_W | Saturating count of memory-wait cycles |

## Verification
The internal state is almost entirely the slot chain, the per-stage reply flags and the queue level, and all of it shows up in output timing. A wrong reply flag or a lost request appears as a retire or writeback pulse that comes early or late, counted from the accepting edge. This is visible within DEPTH plus the stall length cycles. A wrong queue level appears as writeback tags out of order or missing, or as an advance that should have been held. Most of these faults are caught in the first cycles after the permission input is raised. A frozen stage 0 that is handled badly shows up at once in `in_ready`.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  parameter int unsigned TAG_W = 4;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    logic v;
    logic wr;
    logic ld;
    logic st;
    tag_t tag;
  } slot_t;
endpackage

// File: rtl/lsp_mem_track.sv
// Tracks one kind of memory access across the window from its issue stage
// to its check stage. Index 0 is the issue stage, index LAT the check stage.
module lsp_mem_track #(
  parameter int unsigned LAT   = 2,
  parameter int unsigned TAG_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv,
  input  logic [LAT:0]              op,
  input  logic [LAT:0][TAG_W-1:0]   tags,
  input  logic                      rsp_valid,
  input  logic [TAG_W-1:0]          rsp_tag,
  output logic                      req_valid,
  output logic [TAG_W-1:0]          req_tag,
  output logic                      stall
);
  logic [LAT:0] done_q;
  logic [LAT:0] done_eff;
  logic         sent_q;

  always_comb begin
    for (int k = 0; k <= LAT; k++) begin
      done_eff[k] = done_q[k] | (rsp_valid && op[k] && (tags[k] == rsp_tag));
    end
  end

  assign req_valid = op[0] && !sent_q;
  assign req_tag   = tags[0];
  assign stall     = op[LAT] && !done_eff[LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      sent_q <= 1'b0;
    end else if (adv) begin
      sent_q    <= 1'b0;
      done_q[0] <= 1'b0;
      for (int k = 1; k <= LAT; k++) begin
        done_q[k] <= done_eff[k-1];
      end
    end else begin
      sent_q <= sent_q | req_valid;
      done_q <= done_eff;
    end
  end
endmodule

// File: rtl/lsp_wb_fifo.sv
module lsp_wb_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned TAG_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             push,
  input  logic [TAG_W-1:0]                 push_tag,
  input  logic                             grant,
  output logic                             room,
  output logic                             out_valid,
  output logic [TAG_W-1:0]                 out_tag,
  output logic [$clog2(DEPTH+1)-1:0]       level
);
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = $clog2(DEPTH+1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             pop;

  assign pop  = (level != '0) && grant;
  assign room = (level != LVL_W'(DEPTH)) || pop;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    out_tag <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pop;
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end
endmodule

// File: rtl/lsp_pipe.sv
module lsp_pipe
  import lsp_pkg::*;
#(
  parameter int unsigned DEPTH     = 5,
  parameter int unsigned LD_STAGE  = 1,
  parameter int unsigned LD_LAT    = 2,
  parameter int unsigned ST_STAGE  = 2,
  parameter int unsigned ST_LAT    = 1,
  parameter int unsigned WBQ_DEPTH = 2,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pipelined,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_wr,
  input  logic             in_ld,
  input  logic             in_st,
  output logic             ld_req_valid,
  output logic [TAG_W-1:0] ld_req_tag,
  input  logic             ld_rsp_valid,
  input  logic [TAG_W-1:0] ld_rsp_tag,
  output logic             st_req_valid,
  output logic [TAG_W-1:0] st_req_tag,
  input  logic             st_rsp_valid,
  input  logic [TAG_W-1:0] st_rsp_tag,
  input  logic             wr_grant,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic             retire_valid,
  output logic [TAG_W-1:0] retire_tag,
  output logic [CNT_W-1:0] mem_stall_cycles
);
  localparam int unsigned LVL_W = $clog2(WBQ_DEPTH+1);

  slot_t            stg_q [DEPTH];
  slot_t            last;
  slot_t            new_slot;
  logic [DEPTH-1:0] stg_v;
  logic             upper_busy;
  logic             ld_stall, st_stall, mem_stall;
  logic             wbq_room, wb_block, stall, adv, accept, push;
  logic [LVL_W-1:0] wbq_level;

  assign last = stg_q[DEPTH-1];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) stg_v[i] = stg_q[i].v;
  end
  assign upper_busy = |stg_v[DEPTH-2:0];

  assign mem_stall = ld_stall | st_stall;
  assign wb_block  = last.v && last.wr && !wbq_room;
  assign stall     = mem_stall | wb_block;
  assign adv       = !stall;

  assign in_ready = mode_pipelined ? (adv || !stg_q[0].v) : (adv && !upper_busy);
  assign accept   = in_valid && in_ready;
  assign push     = adv && last.v && last.wr;

  always_comb begin
    new_slot     = '0;
    new_slot.v   = 1'b1;
    new_slot.wr  = in_wr;
    new_slot.ld  = in_ld;
    new_slot.st  = in_st;
    new_slot.tag = in_tag;
  end

  // Memory read window
  logic [LD_LAT:0]            ld_op;
  logic [LD_LAT:0][TAG_W-1:0] ld_tags;
  for (genvar k = 0; k <= LD_LAT; k++) begin : g_ld_win
    assign ld_op[k]   = stg_q[LD_STAGE+k].v && stg_q[LD_STAGE+k].ld;
    assign ld_tags[k] = stg_q[LD_STAGE+k].tag;
  end

  lsp_mem_track #(.LAT(LD_LAT), .TAG_W(TAG_W)) u_ld_trk (
    .clk(clk), .rst(rst), .adv(adv), .op(ld_op), .tags(ld_tags),
    .rsp_valid(ld_rsp_valid), .rsp_tag(ld_rsp_tag),
    .req_valid(ld_req_valid), .req_tag(ld_req_tag), .stall(ld_stall)
  );

  // Memory write window
  logic [ST_LAT:0]            st_op;
  logic [ST_LAT:0][TAG_W-1:0] st_tags;
  for (genvar k = 0; k <= ST_LAT; k++) begin : g_st_win
    assign st_op[k]   = stg_q[ST_STAGE+k].v && stg_q[ST_STAGE+k].st;
    assign st_tags[k] = stg_q[ST_STAGE+k].tag;
  end

  lsp_mem_track #(.LAT(ST_LAT), .TAG_W(TAG_W)) u_st_trk (
    .clk(clk), .rst(rst), .adv(adv), .op(st_op), .tags(st_tags),
    .rsp_valid(st_rsp_valid), .rsp_tag(st_rsp_tag),
    .req_valid(st_req_valid), .req_tag(st_req_tag), .stall(st_stall)
  );

  lsp_wb_fifo #(.DEPTH(WBQ_DEPTH), .TAG_W(TAG_W)) u_wbq (
    .clk(clk), .rst(rst), .push(push), .push_tag(last.tag),
    .grant(wr_grant), .room(wbq_room),
    .out_valid(wb_valid), .out_tag(wb_tag), .level(wbq_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      retire_valid     <= 1'b0;
      retire_tag       <= '0;
      mem_stall_cycles <= '0;
    end else begin
      retire_valid <= adv && last.v && !last.wr;
      retire_tag   <= last.tag;
      if (adv) begin
        for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
        stg_q[0] <= accept ? new_slot : '0;
      end else if (accept) begin
        stg_q[0] <= new_slot;
      end
      if (mem_stall && (mem_stall_cycles != {CNT_W{1'b1}}))
        mem_stall_cycles <= mem_stall_cycles + 1'b1;
    end
  end
endmodule

// File: rtl/lsp_pipe_chk.sv
module lsp_pipe_chk #(
  parameter int unsigned DEPTH     = 5,
  parameter int unsigned WBQ_DEPTH = 2,
  parameter int unsigned CNT_W     = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_grant,
  input logic                         wb_valid,
  input logic                         mem_stall,
  input logic [DEPTH-1:0]             stg_v,
  input logic [$clog2(WBQ_DEPTH+1)-1:0] wbq_level,
  input logic [CNT_W-1:0]             cnt
);
  AST_WB_ONLY_GRANTED: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(wr_grant)); // R5

  AST_WBQ_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    wbq_level <= ($clog2(WBQ_DEPTH+1))'(WBQ_DEPTH)); // R6

  AST_MEM_FREEZE: assert property (@(posedge clk) disable iff (rst)
    mem_stall |=> $stable(stg_v[DEPTH-1:1])); // R8

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !mem_stall |=> $stable(cnt)); // R11

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_stall && (cnt != {CNT_W{1'b1}})) |=> (cnt == $past(cnt) + 1'b1)); // R11
endmodule

bind lsp_pipe lsp_pipe_chk #(.DEPTH(DEPTH), .WBQ_DEPTH(WBQ_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_grant(wr_grant), .wb_valid(wb_valid),
  .mem_stall(mem_stall), .stg_v(stg_v), .wbq_level(wbq_level),
  .cnt(mem_stall_cycles)
);

// File: tb/lsp_pipe_tb.sv
`timescale 1ns/1ps
module lsp_pipe_tb;
  localparam int DEPTH = 5;
  localparam int TW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pipelined = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [TW-1:0] in_tag = '0;
  logic in_wr = 1'b0, in_ld = 1'b0, in_st = 1'b0;
  logic ld_req_valid, st_req_valid;
  logic [TW-1:0] ld_req_tag, st_req_tag;
  logic ld_rsp_valid = 1'b0, st_rsp_valid = 1'b0;
  logic [TW-1:0] ld_rsp_tag = '0, st_rsp_tag = '0;
  logic wr_grant = 1'b1;
  logic wb_valid, retire_valid;
  logic [TW-1:0] wb_tag, retire_tag;
  logic [15:0] mem_stall_cycles;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsp_pipe u_dut (
    .clk(clk), .rst(rst), .mode_pipelined(mode_pipelined),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_wr(in_wr), .in_ld(in_ld), .in_st(in_st),
    .ld_req_valid(ld_req_valid), .ld_req_tag(ld_req_tag),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_tag(ld_rsp_tag),
    .st_req_valid(st_req_valid), .st_req_tag(st_req_tag),
    .st_rsp_valid(st_rsp_valid), .st_rsp_tag(st_rsp_tag),
    .wr_grant(wr_grant), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .mem_stall_cycles(mem_stall_cycles)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one instruction; returns after the accepting edge.
  task automatic issue(input int tag, input bit wr, input bit ld, input bit st);
    in_valid = 1'b1; in_tag = TW'(tag); in_wr = wr; in_ld = ld; in_st = st;
    step();
    in_valid = 1'b0; in_wr = 1'b0; in_ld = 1'b0; in_st = 1'b0;
  endtask

  // Steps until retire_valid; returns the number of edges taken.
  task automatic wait_retire(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!retire_valid && n < 40);
  endtask

  task automatic t_reset();
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 wb_valid", int'(wb_valid), 0);
    chk("R1 retire_valid", int'(retire_valid), 0);
    chk("R1 req_valid", int'(ld_req_valid | st_req_valid), 0);
    chk("R1 stall count", int'(mem_stall_cycles), 0);
  endtask

  task automatic t_plain();
    int n;
    chk("R2 ready before issue", int'(in_ready), 1);
    issue(1, 0, 0, 0);
    wait_retire(n);
    chk("R2 latency", n, DEPTH);
    chk("R2 tag", int'(retire_tag), 1);
    step();
    for (int t = 2; t <= 4; t++) begin
      in_valid = 1'b1; in_tag = TW'(t);
      step();
    end
    in_valid = 1'b0;
    wait_retire(n);
    chk("R2 b2b first", int'(retire_tag), 2);
    step();
    chk("R2 b2b second valid", int'(retire_valid), 1);
    chk("R2 b2b second tag", int'(retire_tag), 3);
    step();
    chk("R2 b2b third tag", int'(retire_valid ? retire_tag : 0), 4);
    step();
    chk("R2 b2b end", int'(retire_valid), 0);
  endtask

  task automatic t_sequential();
    int n;
    mode_pipelined = 1'b0;
    #0;
    chk("R3 ready empty", int'(in_ready), 1);
    issue(5, 0, 0, 0);
    chk("R3 busy stage0", int'(in_ready), 0);
    for (int i = 1; i <= DEPTH - 2; i++) begin
      step();
      chk("R3 busy upper", int'(in_ready), 0);
    end
    step();
    chk("R3 ready at last stage", int'(in_ready), 1);
    wait_retire(n);
    chk("R3 retire tag", int'(retire_tag), 5);
    mode_pipelined = 1'b1;
    step();
  endtask

  task automatic t_writeback();
    int seen;
    wr_grant = 1'b0;
    issue(8, 1, 0, 0);
    issue(9, 1, 0, 0);
    seen = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      step();
      if (wb_valid) seen++;
    end
    chk("R5 no writeback without grant", seen, 0);
    wr_grant = 1'b1;
    step();
    chk("R4 first wb valid", int'(wb_valid), 1);
    chk("R4 first wb tag", int'(wb_tag), 8);
    step();
    chk("R4 second wb tag", int'(wb_valid ? wb_tag : 0), 9);
    step();
    chk("R4 queue drained", int'(wb_valid), 0);
  endtask

  task automatic t_wbq_full();
    int base, seen, n;
    base = int'(mem_stall_cycles);
    wr_grant = 1'b0;
    issue(10, 1, 0, 0);
    issue(11, 1, 0, 0);
    issue(12, 1, 0, 0);
    issue(13, 0, 0, 0);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (retire_valid) seen++;
    end
    chk("R6 frozen no retire", seen, 0);
    chk("R12 ready stage0 empty", int'(in_ready), 1);
    issue(14, 0, 0, 0);
    chk("R12 not ready stage0 full", int'(in_ready), 0);
    chk("R11 wb stall not counted", int'(mem_stall_cycles), base);
    wr_grant = 1'b1;
    step();
    chk("R6 wb A", int'(wb_valid ? wb_tag : 0), 10);
    step();
    chk("R6 wb B", int'(wb_valid ? wb_tag : 0), 11);
    chk("R6 D retires after release", int'(retire_valid ? retire_tag : 0), 13);
    step();
    chk("R6 wb C", int'(wb_valid ? wb_tag : 0), 12);
    wait_retire(n);
    chk("R12 E retires", int'(retire_tag), 14);
    step();
  endtask

  task automatic t_load_late();
    int base, n;
    base = int'(mem_stall_cycles);
    issue(5, 0, 1, 0);
    chk("R7 no req at stage0", int'(ld_req_valid), 0);
    step();
    chk("R7 req at load stage", int'(ld_req_valid), 1);
    chk("R7 req tag", int'(ld_req_tag), 5);
    step();
    chk("R7 req one cycle", int'(ld_req_valid), 0);
    step();
    for (int i = 0; i < 4; i++) step();
    chk("R11 four stalled cycles", int'(mem_stall_cycles) - base, 4);
    ld_rsp_valid = 1'b1; ld_rsp_tag = 4'd5;
    step();
    ld_rsp_valid = 1'b0;
    step();
    chk("R8 delayed retire", int'(retire_valid ? retire_tag : 0), 5);
    chk("R8 stall count final", int'(mem_stall_cycles) - base, 4);
    n = 0;
    step();
  endtask

  task automatic t_load_early();
    int base, n;
    base = int'(mem_stall_cycles);
    issue(6, 0, 1, 0);
    step();
    chk("R9 req raised", int'(ld_req_valid), 1);
    ld_rsp_valid = 1'b1; ld_rsp_tag = 4'd6;
    step();
    ld_rsp_valid = 1'b0;
    wait_retire(n);
    chk("R9 no delay with early reply", n + 2, DEPTH);
    chk("R9 tag", int'(retire_tag), 6);
    chk("R9 no stall counted", int'(mem_stall_cycles), base);
    step();
  endtask

  task automatic t_store();
    int base, n;
    base = int'(mem_stall_cycles);
    issue(7, 0, 0, 1);
    step();
    chk("R10 no store req before stage", int'(st_req_valid), 0);
    step();
    chk("R10 store req", int'(st_req_valid), 1);
    chk("R10 store req tag", int'(st_req_tag), 7);
    step();
    step();
    step();
    st_rsp_valid = 1'b1; st_rsp_tag = 4'd7;
    step();
    st_rsp_valid = 1'b0;
    step();
    chk("R10 store delayed retire", int'(retire_valid ? retire_tag : 0), 7);
    chk("R10 store stall count", int'(mem_stall_cycles) - base, 2);
    n = 0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    #0;
    t_reset();
    t_plain();
    t_sequential();
    t_writeback();
    t_wbq_full();
    t_load_late();
    t_load_early();
    t_store();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule